// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This unit does decimal arithmetic on bytes that hold two packed binary-coded decimal digits, one per nibble. It can add, subtract or negate, and it takes an incoming extend bit as carry-in or borrow-in. Wider decimal numbers are processed one byte at a time, lowest byte first. The extend output of one step feeds the extend input of the next, and the zero output of one step feeds the zero input of the next.

Each decimal digit has its own correction cell. These cells form a ripple chain, so the digit count is a parameter. The result byte and the three flags update together on the clock edge where the strobe is high and a legal operation is selected. At every other edge they hold their values. The zero flag can only be cleared, never set, by an operation. This means a chain of bytes ends with Z high only if every byte of the chain gave zero.

Top module: `bcd_byte_alu`

## Requirements
- R1: With op = 2'b00 (add), the result is the decimal value (dst + src + x_in) mod 100, and the carry is 1 when that sum is 100 or more.
- R2: With op = 2'b01 (subtract), the result is (dst - src - x_in), with 100 added when the difference is negative; the borrow is 1 exactly in that case.
- R3: With op = 2'b10 (negate), the result is (0 - dst - x_in), with 100 added when negative; the borrow is 1 whenever dst or x_in is nonzero.
- R4: x_out and c_out both take the carry or borrow out of the highest digit.
- R5: z_out becomes 0 when the committed result is nonzero. Otherwise it becomes z_in, so it can never be raised by an operation.
- R6: Results and flags change only on a clock edge where en = 1. They appear one cycle after that edge, and with en = 0 all outputs hold.
- R7: op = 2'b11 is reserved, and with it a strobe changes no output.
- R8: Digits above 9 give results defined per digit, as follows.
  - When adding, a digit sum above 9 has 6 added to it mod 16 and carries out.
  - When subtracting, a negative digit difference has 10 added to it mod 16 and borrows out.
  - Example: 0x0A + 0x00 gives 0x10 with no carry.
  - Example: 0x0F - 0x00 gives 0x0F.
  - Example: negating 0xAA gives 0xF0 with borrow.
- R9: A synchronous active-high reset clears res, x_out, c_out and z_out to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Commit strobe |
| op | input | 2 | Operation: 00 add, 01 subtract, 10 negate, 11 reserved |
| src | input | 4*DIGITS | Source operand (packed BCD) |
| dst | input | 4*DIGITS | Destination operand (packed BCD) |
| x_in | input | 1 | Extend bit, used as carry-in or borrow-in |
| z_in | input | 1 | Zero flag from the previous step |
| res | output | 4*DIGITS | Registered result |
| x_out | output | 1 | Registered extend flag |
| c_out | output | 1 | Registered carry/borrow flag |
| z_out | output | 1 | Registered sticky zero flag |

## Verification
Add and subtract are swept over every pair of valid two-digit operands, with both extend values. Z-in alternates between the pairs, so the sweep separates:
- digit corrections that fire with and without a carry between nibbles;
- wrap-around at 99 and at 00;
- the sticky zero rule, including zero results reached with a carry out.

Negate is swept over every valid operand with both extend values. This tells apart the single case with no borrow (zero with x clear) from all the others. Separate patterns cover:
- hand-computed results for invalid digits;
- holding while the strobe is low;
- the reserved code;
- a reset taken after a nonzero result.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int DIGIT_W = 4;

  typedef enum logic [1:0] {
    BCD_ADD = 2'b00,
    BCD_SUB = 2'b01,
    BCD_NEG = 2'b10,
    BCD_RSV = 2'b11
  } bcd_op_e;
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_alu_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  input  logic               cin_i,
  input  logic               sub_i,
  output logic [DIGIT_W-1:0] r_o,
  output logic               cout_o
);
  logic [DIGIT_W:0] sum_w;
  logic [DIGIT_W:0] dif_w;
  logic             add_adj;
  logic             sub_bor;

  always_comb begin
    sum_w   = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, cin_i};
    dif_w   = {1'b0, a_i} - {1'b0, b_i} - {{DIGIT_W{1'b0}}, cin_i};
    add_adj = (sum_w > (DIGIT_W+1)'(9));
    sub_bor = dif_w[DIGIT_W];
    if (sub_i) begin
      // negative difference: +10 mod 16 is the same as -6 on the low nibble
      r_o    = sub_bor ? (dif_w[DIGIT_W-1:0] - DIGIT_W'(6)) : dif_w[DIGIT_W-1:0];
      cout_o = sub_bor;
    end else begin
      r_o    = add_adj ? (sum_w[DIGIT_W-1:0] + DIGIT_W'(6)) : sum_w[DIGIT_W-1:0];
      cout_o = add_adj;
    end
  end

  // valid decimal digits in give a valid decimal digit out (R1, R2, R3)
  always_comb begin
    if (a_i < DIGIT_W'(10) && b_i < DIGIT_W'(10)) begin
      assert_digit_range_R1: assert (r_o < DIGIT_W'(10))
        else $error("digit out of range");
    end
  end
endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
  import bcd_alu_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] r_o,
  output logic         cout_o
);
  logic [DIGITS:0] carry;

  assign carry[0] = cin_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_cell u_cell (
      .a_i   (a_i[g*DIGIT_W +: DIGIT_W]),
      .b_i   (b_i[g*DIGIT_W +: DIGIT_W]),
      .cin_i (carry[g]),
      .sub_i (sub_i),
      .r_o   (r_o[g*DIGIT_W +: DIGIT_W]),
      .cout_o(carry[g+1])
    );
  end

  assign cout_o = carry[DIGITS];
endmodule

// File: rtl/bcd_operand_sel.sv
module bcd_operand_sel
  import bcd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         sub_o,
  output logic         legal_o
);
  bcd_op_e op_e;

  always_comb begin
    op_e    = bcd_op_e'(op_i);
    a_o     = dst_i;
    b_o     = src_i;
    sub_o   = 1'b0;
    legal_o = 1'b1;
    unique case (op_e)
      BCD_ADD: ;
      BCD_SUB: sub_o = 1'b1;
      BCD_NEG: begin
        a_o   = '0;
        b_o   = dst_i;
        sub_o = 1'b1;
      end
      BCD_RSV: legal_o = 1'b0;
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcd_flag_reg.sv
module bcd_flag_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         legal_i,
  input  logic [W-1:0] r_i,
  input  logic         cout_i,
  input  logic         z_i,
  output logic [W-1:0] res_q,
  output logic         x_q,
  output logic         c_q,
  output logic         z_q
);
  logic commit;
  assign commit = en_i & legal_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      x_q   <= 1'b0;
      c_q   <= 1'b0;
      z_q   <= 1'b0;
    end else if (commit) begin
      res_q <= r_i;
      x_q   <= cout_i;
      c_q   <= cout_i;
      z_q   <= (r_i == '0) ? z_i : 1'b0;
    end
  end

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (res_q == '0 && !x_q && !c_q && !z_q));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ($stable(res_q) && $stable(x_q) && $stable(c_q) && $stable(z_q)));

  assert_reserved_noop_R7: assert property (@(posedge clk) disable iff (rst)
    (en_i && !legal_i) |=> ($stable(res_q) && $stable(z_q) && $stable(x_q)));

  assert_zero_never_raised_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && !z_i) |=> !z_q);

  assert_zero_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    commit |=> (res_q == '0 || !z_q));

  assert_flags_agree_R4: assert property (@(posedge clk) disable iff (rst)
    commit |=> (x_q == c_q));
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
  import bcd_alu_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [1:0]   op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic         x_in,
  input  logic         z_in,
  output logic [W-1:0] res,
  output logic         x_out,
  output logic         c_out,
  output logic         z_out
);
  logic [W-1:0] opa, opb, sum;
  logic         is_sub, legal, cy;

  bcd_operand_sel #(.W(W)) u_sel (
    .op_i   (op),
    .src_i  (src),
    .dst_i  (dst),
    .a_o    (opa),
    .b_o    (opb),
    .sub_o  (is_sub),
    .legal_o(legal)
  );

  bcd_digit_chain #(.DIGITS(DIGITS)) u_chain (
    .a_i   (opa),
    .b_i   (opb),
    .cin_i (x_in),
    .sub_i (is_sub),
    .r_o   (sum),
    .cout_o(cy)
  );

  bcd_flag_reg #(.W(W)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en),
    .legal_i(legal),
    .r_i    (sum),
    .cout_i (cy),
    .z_i    (z_in),
    .res_q  (res),
    .x_q    (x_out),
    .c_q    (c_out),
    .z_q    (z_out)
  );
endmodule

// File: tb/bcd_byte_alu_bench.sv
module bcd_byte_alu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] src = 8'h00, dst = 8'h00;
  logic       x_in = 1'b0, z_in = 1'b0;
  logic [7:0] res;
  logic       x_out, c_out, z_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bcd_byte_alu u_bcd_byte_alu (
    .clk(clk), .rst(rst), .en(en), .op(op), .src(src), .dst(dst),
    .x_in(x_in), .z_in(z_in), .res(res), .x_out(x_out), .c_out(c_out), .z_out(z_out)
  );

  always #4 clk = ~clk;

  function automatic int dec(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] tobcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic expect_out(input string tag, input logic [7:0] er,
                            input logic ec, input logic ez);
    checks++;
    if (res !== er || x_out !== ec || c_out !== ec || z_out !== ez) begin
      fails++;
      $display("FAIL %s: res=%h x=%b c=%b z=%b expected res=%h x=%b c=%b z=%b",
               tag, res, x_out, c_out, z_out, er, ec, ec, ez);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [7:0] s, input logic [7:0] d,
                        input logic x, input logic z);
    @(negedge clk);
    op = o; src = s; dst = d; x_in = x; z_in = z; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  // decimal model: returns result and carry/borrow
  task automatic model(input logic [1:0] o, input logic [7:0] s, input logic [7:0] d,
                       input logic x, output logic [7:0] r, output logic cy);
    int v;
    if (o == 2'b00) begin
      v = dec(d) + dec(s) + int'(x);
      cy = (v >= 100);
      if (cy) v -= 100;
    end else begin
      if (o == 2'b01) v = dec(d) - dec(s) - int'(x);
      else            v = 0 - dec(d) - int'(x);
      cy = (v < 0);
      if (cy) v += 100;
    end
    r = tobcd(v);
  endtask

  initial begin
    logic [7:0] er;
    logic       ec;
    repeat (3) @(negedge clk);
    expect_out("R9 reset state", 8'h00, 1'b0, 1'b0);
    rst = 1'b0;

    // R1 add and R2 subtract: full sweep over valid operands
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 100; i++) begin
        for (int j = 0; j < 100; j++) begin
          for (int x = 0; x < 2; x++) begin
            logic zi;
            zi = logic'((i + j + x) % 2 == 0);
            model(2'(k), tobcd(j), tobcd(i), logic'(x), er, ec);
            run_op(2'(k), tobcd(j), tobcd(i), logic'(x), zi);
            expect_out(k == 0 ? "R1 R4 R5 add" : "R2 R4 R5 sub", er, ec,
                       zi & (er == 8'h00));
          end
        end
      end
    end

    // R3 negate sweep
    for (int i = 0; i < 100; i++) begin
      for (int x = 0; x < 2; x++) begin
        model(2'b10, 8'h55, tobcd(i), logic'(x), er, ec);
        run_op(2'b10, 8'h55, tobcd(i), logic'(x), 1'b1);
        expect_out("R3 R4 R5 neg", er, ec, er == 8'h00);
      end
    end

    // R5 sticky chain: 0x00 + 0x00 with z_in low stays low
    run_op(2'b00, 8'h00, 8'h00, 1'b0, 1'b0);
    expect_out("R5 zero result keeps z_in low", 8'h00, 1'b0, 1'b0);
    run_op(2'b00, 8'h01, 8'h99, 1'b0, 1'b1);
    expect_out("R5 zero with carry keeps z_in high", 8'h00, 1'b1, 1'b1);

    // R8 invalid digits
    run_op(2'b00, 8'h00, 8'h0A, 1'b0, 1'b1);
    expect_out("R8 add invalid digit", 8'h10, 1'b0, 1'b0);
    run_op(2'b01, 8'h00, 8'h0F, 1'b0, 1'b1);
    expect_out("R8 sub invalid digit", 8'h0F, 1'b0, 1'b0);
    run_op(2'b10, 8'h00, 8'hAA, 1'b0, 1'b1);
    expect_out("R8 neg invalid digits", 8'hF0, 1'b1, 1'b0);

    // R6 hold with strobe low
    run_op(2'b00, 8'h45, 8'h37, 1'b1, 1'b1);
    expect_out("R6 setup add", 8'h83, 1'b0, 1'b0);
    @(negedge clk);
    op = 2'b01; src = 8'h99; dst = 8'h00; x_in = 1'b1; z_in = 1'b1;
    repeat (2) @(negedge clk);
    expect_out("R6 hold while en low", 8'h83, 1'b0, 1'b0);

    // R7 reserved op with strobe
    run_op(2'b11, 8'h00, 8'h00, 1'b1, 1'b1);
    expect_out("R7 reserved op ignored", 8'h83, 1'b0, 1'b0);

    // R9 reset after nonzero result
    run_op(2'b01, 8'h01, 8'h00, 1'b0, 1'b1);
    expect_out("R2 setup borrow", 8'h99, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expect_out("R9 reset clears", 8'h00, 1'b0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule